// File: doc/BRIEF.md
# Masked Packed Float-to-Int64 Truncating Converter

This block turns packed IEEE-754 single-precision values into signed 64-bit integers, always rounding toward zero. One operation converts 2, 4 or 8 lanes, according to a vector-length select. The matching part of the 512-bit result is filled, and every bit above the selected length is cleared. A per-lane write mask decides which lanes receive a converted value. A lane that is not written either keeps its previous destination contents (merge) or is cleared (zeroing).

A broadcast select feeds the lowest source element to every lane. Values that cannot be represented return a fixed indefinite pattern and raise an invalid flag. Discarded fractions raise an inexact flag. Both flags are sticky until reset. A 4-bit reserved operand field must read all ones; any other value raises an illegal-encoding output.

The unit is a single registered stage. An input strobe produces registered results and an output strobe one cycle later.

Top module: `pk_f2i64_cvt`

## Requirements
- R1: Every lane converts toward zero by discarding the fraction. Examples: 2.75 gives 2 and -2.75 gives -2. A nonzero discarded fraction sets the inexact flag.
- R2: `vlen_sel` encodes the lane count as 0 = 2 lanes, 1 = 4 lanes, and 2 or 3 = 8 lanes. Lane j reads `src[j*32+31:j*32]` and writes `result[j*64+63:j*64]`.
- R3: The following inputs return 0x8000_0000_0000_0000 and set the invalid flag: NaN, either infinity, any value at or above +2^63, and any value below -2^63. Exactly -2^63 converts without error.
- R4: Zero, negative zero and subnormal inputs give 0. Subnormals and any nonzero magnitude below 1.0 set inexact.
- R5: With `mask_en` low, every active lane is written. With `mask_en` high, active lane j is written only when `mask[j]` is 1.
- R6: An active lane that is not written keeps `old_dst`'s lane when `zero_mode` is 0 and becomes zero when `zero_mode` is 1.
- R7: With `bcast` high, every written lane converts `src[31:0]`.
- R8: All result bits from the selected vector length up to bit 511 are zero.
- R9: `flag_invalid` and `flag_inexact` accumulate across operations and clear only on reset. Only written lanes contribute to them.
- R10: `illegal_enc` is updated with each operation. It is 1 when `resv_field` is not 4'b1111 and 0 otherwise.
- R11: `result`, `illegal_enc` and the flags update on the clock edge that samples `in_valid`. `out_valid` is high only in the following cycle. `result` holds while no operation is issued.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 256 | Packed single-precision source lanes |
| vlen_sel | input | 2 | Vector length code |
| mask | input | 8 | Per-lane write mask |
| mask_en | input | 1 | Enables the write mask |
| zero_mode | input | 1 | 1 = zero unwritten lanes, 0 = merge |
| bcast | input | 1 | Broadcast lowest source element |
| old_dst | input | 512 | Prior destination value for merging |
| resv_field | input | 4 | Reserved operand field, must be 1111b |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 512 | Converted, masked result |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_inexact | output | 1 | Sticky inexact flag |
| illegal_enc | output | 1 | Reserved field was not all ones |

## Verification
The bench builds the block with its default parameters: eight lanes of 32-bit input and 64-bit output. At this size all three vector lengths and the spare length code are reachable, as are lanes that lie above the active length. A table of single values walks the exponent boundaries of the conversion: below one, the exact-integer point, the largest finite value under 2^63, exactly ±2^63, and infinities, NaN and subnormals. Directed cases then combine masks, merge and zeroing, broadcast, and flag accumulation across several operations.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int FP_W      = 32;
  localparam int FP_EXP_W  = 8;
  localparam int FP_MAN_W  = 23;
  localparam int FP_BIAS   = 127;
  localparam int INT_W     = 64;
  // exponent at which the mantissa LSB weighs exactly 1
  localparam int EXP_UNIT  = FP_BIAS + FP_MAN_W;
  // exponent of 2^(INT_W-1), first out-of-range magnitude
  localparam int EXP_LIMIT = FP_BIAS + INT_W - 1;
  localparam logic [INT_W-1:0] INT_INDEF = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [FP_EXP_W-1:0] EXP_SPECIAL = {FP_EXP_W{1'b1}};
  localparam logic [3:0] RESV_OK = 4'b1111;
endpackage

// File: rtl/f2i_trunc_lane.sv
module f2i_trunc_lane
  import cvt_pkg::*;
(
  input  logic [FP_W-1:0]  fp_in,
  output logic [INT_W-1:0] int_out,
  output logic             inv,
  output logic             inx
);
  localparam int MANT_W = FP_MAN_W + 1;

  logic                sgn;
  logic [FP_EXP_W-1:0] ex;
  logic [FP_MAN_W-1:0] fr;
  logic [MANT_W-1:0]   mant;
  logic [INT_W-1:0]    mag;
  logic [FP_EXP_W-1:0] sh_l;
  logic [FP_EXP_W-1:0] sh_r;
  logic [MANT_W-1:0]   low_mask;

  always_comb begin
    sgn      = fp_in[FP_W-1];
    ex       = fp_in[FP_W-2:FP_MAN_W];
    fr       = fp_in[FP_MAN_W-1:0];
    mant     = {(ex != '0), fr};
    sh_l     = ex - FP_EXP_W'(EXP_UNIT);
    sh_r     = FP_EXP_W'(EXP_UNIT) - ex;
    low_mask = '0;
    mag      = '0;
    inv      = 1'b0;
    inx      = 1'b0;
    if (ex == EXP_SPECIAL) begin
      inv = 1'b1;
    end else if (ex >= FP_EXP_W'(EXP_LIMIT)) begin
      if (sgn && ex == FP_EXP_W'(EXP_LIMIT) && fr == '0)
        mag = INT_INDEF;
      else
        inv = 1'b1;
    end else if (ex < FP_EXP_W'(FP_BIAS)) begin
      inx = (ex != '0) || (fr != '0);
    end else if (ex >= FP_EXP_W'(EXP_UNIT)) begin
      mag = {{(INT_W-MANT_W){1'b0}}, mant} << sh_l[5:0];
    end else begin
      mag      = {{(INT_W-MANT_W){1'b0}}, mant} >> sh_r[4:0];
      low_mask = (MANT_W'(1) << sh_r[4:0]) - MANT_W'(1);
      inx      = |(mant & low_mask);
    end
    if (inv)
      int_out = INT_INDEF;
    else if (sgn)
      int_out = -mag;
    else
      int_out = mag;
  end
endmodule

// File: rtl/lane_write_gate.sv
module lane_write_gate #(
  parameter int OUT_W = 64
) (
  input  logic             active,
  input  logic             mask_bit,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [OUT_W-1:0] conv,
  input  logic [OUT_W-1:0] prior,
  input  logic             inv_in,
  input  logic             inx_in,
  output logic [OUT_W-1:0] lane_out,
  output logic             inv_out,
  output logic             inx_out
);
  logic wr;

  always_comb begin
    wr = active && (!mask_en || mask_bit);
    if (!active)
      lane_out = '0;
    else if (wr)
      lane_out = conv;
    else if (zero_mode)
      lane_out = '0;
    else
      lane_out = prior;
    inv_out = wr && inv_in;
    inx_out = wr && inx_in;
  end
endmodule

// File: rtl/pk_f2i64_cvt.sv
module pk_f2i64_cvt
  import cvt_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int SEL_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [NUM_LANES*FP_W-1:0]  src,
  input  logic [SEL_W-1:0]           vlen_sel,
  input  logic [NUM_LANES-1:0]       mask,
  input  logic                       mask_en,
  input  logic                       zero_mode,
  input  logic                       bcast,
  input  logic [NUM_LANES*INT_W-1:0] old_dst,
  input  logic [3:0]                 resv_field,
  output logic                       out_valid,
  output logic [NUM_LANES*INT_W-1:0] result,
  output logic                       flag_invalid,
  output logic                       flag_inexact,
  output logic                       illegal_enc
);
  localparam int DST_W  = NUM_LANES * INT_W;
  localparam int CNT_W  = $clog2(NUM_LANES + 1);
  localparam int MIN_LN = 2;

  logic [CNT_W-1:0]      lane_cnt;
  logic [DST_W-1:0]      nxt_result;
  logic [NUM_LANES-1:0]  lane_inv;
  logic [NUM_LANES-1:0]  lane_inx;

  // lane count doubles per code step, saturating at the full width
  always_comb begin
    if (int'(vlen_sel) >= $clog2(NUM_LANES / MIN_LN))
      lane_cnt = CNT_W'(NUM_LANES);
    else
      lane_cnt = CNT_W'(MIN_LN << vlen_sel);
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    logic [FP_W-1:0]  elem;
    logic [INT_W-1:0] conv;
    logic             c_inv;
    logic             c_inx;

    assign elem = bcast ? src[FP_W-1:0] : src[j*FP_W +: FP_W];

    f2i_trunc_lane u_conv (
      .fp_in   (elem),
      .int_out (conv),
      .inv     (c_inv),
      .inx     (c_inx)
    );

    lane_write_gate #(.OUT_W(INT_W)) u_gate (
      .active    (CNT_W'(j) < lane_cnt),
      .mask_bit  (mask[j]),
      .mask_en   (mask_en),
      .zero_mode (zero_mode),
      .conv      (conv),
      .prior     (old_dst[j*INT_W +: INT_W]),
      .inv_in    (c_inv),
      .inx_in    (c_inx),
      .lane_out  (nxt_result[j*INT_W +: INT_W]),
      .inv_out   (lane_inv[j]),
      .inx_out   (lane_inx[j])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      result       <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      illegal_enc  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result       <= nxt_result;
        flag_invalid <= flag_invalid | (|lane_inv);
        flag_inexact <= flag_inexact | (|lane_inx);
        illegal_enc  <= (resv_field != RESV_OK);
      end
    end
  end

  a_r11_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_invalid_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_invalid |=> flag_invalid);
  a_r9_inexact_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_inexact |=> flag_inexact);
  a_r8_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == '0) |=> (result[DST_W-1:MIN_LN*INT_W] == '0));
  a_r10_bad_field_flagged: assert property (@(posedge clk) disable iff (rst)
    (in_valid && resv_field != RESV_OK) |=> illegal_enc);
  a_r6_merge_lane0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !mask[0] && !zero_mode)
      |=> (result[INT_W-1:0] == $past(old_dst[INT_W-1:0])));
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !$past(rst)) |=> $stable(result));
endmodule

// File: tb/pk_f2i64_cvt_tb.sv
module pk_f2i64_cvt_tb;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic [255:0] src;
  logic [1:0]   vlen_sel;
  logic [7:0]   mask;
  logic         mask_en, zero_mode, bcast;
  logic [511:0] old_dst;
  logic [3:0]   resv_field;
  logic         out_valid;
  logic [511:0] result;
  logic         flag_invalid, flag_inexact, illegal_enc;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pk_f2i64_cvt u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .vlen_sel(vlen_sel),
    .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
    .old_dst(old_dst), .resv_field(resv_field), .out_valid(out_valid),
    .result(result), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
    .illegal_enc(illegal_enc)
  );

  localparam logic [63:0] INDEF = 64'h8000_0000_0000_0000;
  // {float bits, expected int, expected invalid, expected inexact}
  localparam logic [97:0] TBL [16] = '{
    {32'h3F80_0000, 64'd1,                   1'b0, 1'b0},
    {32'h4030_0000, 64'd2,                   1'b0, 1'b1},
    {32'hC030_0000, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1},
    {32'h3F00_0000, 64'd0,                   1'b0, 1'b1},
    {32'h8000_0000, 64'd0,                   1'b0, 1'b0},
    {32'h0000_0000, 64'd0,                   1'b0, 1'b0},
    {32'h0000_0001, 64'd0,                   1'b0, 1'b1},
    {32'h7F80_0000, INDEF,                   1'b1, 1'b0},
    {32'hFF80_0000, INDEF,                   1'b1, 1'b0},
    {32'h7FC0_0000, INDEF,                   1'b1, 1'b0},
    {32'h5F00_0000, INDEF,                   1'b1, 1'b0},
    {32'hDF00_0001, INDEF,                   1'b1, 1'b0},
    {32'hDF00_0000, INDEF,                   1'b0, 1'b0},
    {32'h5EFF_FFFF, 64'h7FFF_FF80_0000_0000, 1'b0, 1'b0},
    {32'h4B00_0001, 64'd8388609,             1'b0, 1'b0},
    {32'h42F6_E979, 64'd123,                 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; src = '0; vlen_sel = 0; mask = '0; mask_en = 0;
    zero_mode = 0; bcast = 0; old_dst = '0; resv_field = 4'b1111;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; idle_inputs();
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  // pulse in_valid for one edge; returns at the following negedge
  task automatic issue();
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [31:0] fint(input int v);
    case (v)
      1: return 32'h3F80_0000; 2: return 32'h4000_0000;
      3: return 32'h4040_0000; 4: return 32'h4080_0000;
      5: return 32'h40A0_0000; 6: return 32'h40C0_0000;
      7: return 32'h40E0_0000; default: return 32'h4100_0000;
    endcase
  endfunction

  task automatic load_ramp();
    for (int j = 0; j < 8; j++) src[j*32 +: 32] = fint(j + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; idle_inputs();
    repeat (3) @(negedge clk);
    rst = 0;
    // R12 reset state
    chk("R12 result", result[63:0] | result[511:448], 64'd0);
    chk("R12 flags", {60'd0, out_valid, flag_invalid, flag_inexact, illegal_enc}, 64'd0);

    // table walk: R1 R3 R4 conversions in lane 0
    for (int t = 0; t < 16; t++) begin
      do_reset();
      src[31:0] = TBL[t][97:66];
      issue();
      chk("R1/R3/R4 value", result[63:0], TBL[t][65:2]);
      chk("R3 invalid flag", {63'd0, flag_invalid}, {63'd0, TBL[t][1]});
      chk("R1/R4 inexact flag", {63'd0, flag_inexact}, {63'd0, TBL[t][0]});
      chk("R8 upper zero", result[511:448] | result[191:128], 64'd0);
    end

    // R2 lane mapping, 8 lanes, then R11 timing
    do_reset(); load_ramp(); vlen_sel = 2;
    in_valid = 1;
    @(negedge clk);
    chk("R11 out_valid high", {63'd0, out_valid}, 64'd1);
    in_valid = 0;
    for (int j = 0; j < 8; j++) chk("R2 lane 8-wide", result[j*64 +: 64], 64'(j + 1));
    @(negedge clk);
    chk("R11 out_valid drops", {63'd0, out_valid}, 64'd0);
    src = '0;
    @(negedge clk);
    chk("R11 result holds", result[511:448], 64'd8);

    // R2 4 lanes, R8 above zero
    do_reset(); load_ramp(); vlen_sel = 1; issue();
    for (int j = 0; j < 4; j++) chk("R2 lane 4-wide", result[j*64 +: 64], 64'(j + 1));
    for (int j = 4; j < 8; j++) chk("R8 beyond 256", result[j*64 +: 64], 64'd0);

    // R2 spare code 3 gives 8 lanes
    do_reset(); load_ramp(); vlen_sel = 3; issue();
    chk("R2 code3 lane7", result[511:448], 64'd8);

    // R5 R6 merge
    do_reset(); load_ramp(); vlen_sel = 2; mask_en = 1; mask = 8'b1010_0101;
    for (int j = 0; j < 8; j++) old_dst[j*64 +: 64] = 64'hAAAA_0000_0000_0000 + 64'(j);
    issue();
    for (int j = 0; j < 8; j++)
      chk("R5/R6 merge", result[j*64 +: 64],
          mask[j] ? 64'(j + 1) : 64'hAAAA_0000_0000_0000 + 64'(j));
    // R6 zeroing
    zero_mode = 1; issue();
    for (int j = 0; j < 8; j++)
      chk("R6 zeroing", result[j*64 +: 64], mask[j] ? 64'(j + 1) : 64'd0);
    // R5 mask ignored when mask_en low
    mask_en = 0; mask = 8'h00; issue();
    chk("R5 no masking", result[127:64], 64'd2);

    // R7 broadcast of -3.0
    do_reset(); load_ramp(); src[31:0] = 32'hC040_0000; bcast = 1; vlen_sel = 2; issue();
    for (int j = 0; j < 8; j++) chk("R7 broadcast", result[j*64 +: 64], 64'hFFFF_FFFF_FFFF_FFFD);

    // R9 flags only from written lanes
    do_reset(); src[31:0] = 32'h3F80_0000; src[63:32] = 32'h7FC0_0000;
    src[95:64] = 32'h7FC0_0000; src[127:96] = 32'h3F00_0000;
    mask_en = 1; mask = 8'b1111_1101; vlen_sel = 0; issue();
    chk("R9 masked/inactive no flags", {62'd0, flag_invalid, flag_inexact}, 64'd0);
    // R9 sticky
    mask_en = 0; issue();
    chk("R9 invalid set", {63'd0, flag_invalid}, 64'd1);
    src[63:32] = 32'h3F80_0000; issue();
    chk("R9 invalid sticky", {63'd0, flag_invalid}, 64'd1);
    do_reset();
    chk("R9 reset clears", {63'd0, flag_invalid}, 64'd0);

    // R10 illegal encoding
    resv_field = 4'b1110; issue();
    chk("R10 illegal set", {63'd0, illegal_enc}, 64'd1);
    resv_field = 4'b1111; issue();
    chk("R10 illegal clear", {63'd0, illegal_enc}, 64'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule